// File: doc/BRIEF.md
# Network Interface Interrupt Status and Coalescing Unit

This block collects interrupt causes for a network interface into a nine-bit pending-status word. Eight causes arrive as single-cycle hardware pulses from the receive and transmit paths. The ninth cause is raised by software through a command write. Each pending bit is gated by a per-source enable mask and by a global enable before it reaches the single interrupt line.

Sources fall into two fixed classes. Urgent conditions drive the line as soon as their status bit is set: FIFO empty, FIFO above or below a watermark, FIFO full, and the software request. Completion-type events (packet arrival, DMA done, and a spare receive-side cause) are coalesced. The first such event starts a programmable cycle countdown, and the line is raised only when the countdown runs out, so a burst of completions costs one interrupt. The host reads the status word to learn the causes, and that read clears them.

The register port is word addressed. Writes take effect at the clock edge. Read data appears on the cycle after the read strobe.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset the status reads 0, the mask reads 0x1FF, the configuration reads 0, the delay reads 0 and `irq_o` is low. Register word addresses are: 0 configuration, 1 command, 2 status, 3 mask, 4 delay.
- R2: A pulse on `evt_i[i]` sets status bit i in the next cycle. Status bits 9 and above always read 0. Bit meanings: 0 packet received, 1 rx DMA done, 2 rx FIFO empty, 3 rx above high watermark, 4 spare rx cause, 5 tx DMA done, 6 tx FIFO full, 7 tx below low watermark, 8 software request.
- R3: A write to the command word with bit 1 set and bit 0 clear sets status bit 8.
- R4: An enabled, unmasked source in the immediate group (mask 0x1CC: bits 2, 3, 6, 7, 8) drives `irq_o` high in the same cycle its status bit becomes visible.
- R5: Sources in the coalesced group (bits 0, 1, 4, 5) raise `irq_o` D+1 cycles after the first of them becomes pending, where D is the delay word (16 bits). Further coalesced events during the countdown do not restart it.
- R6: A status read returns the pending bits one cycle later and clears them. An event arriving in the read cycle stays set.
- R7: A mask bit at 0 keeps that source from affecting `irq_o`, but its status bit is still recorded.
- R8: With configuration bit 2 at 0, `irq_o` stays low. Setting it releases any pending enabled interrupt.
- R9: A command write with bit 0 set returns status, mask, configuration, delay and the countdown to their reset values. This takes priority over bit 1 in the same write.
- R10: `irq_o` falls in the cycle after the read that clears its last enabled pending cause.
- R11: With a delay of 0, a coalesced source raises `irq_o` one cycle after its status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Hardware cause pulses, one per status bit 0..7 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (3) | Register word address |
| reg_wdata | input | REG_W (32) | Write data |
| reg_rdata | output | REG_W (32) | Read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Interrupt line |

## Verification
Single immediate pulses check that the line rises with no delay and drops after the clearing read. A coalesced pulse followed by a second coalesced pulse in mid-countdown shows whether the timer restarts, and a zero delay shows whether that edge case is off by one. A read that coincides with a new event shows whether the clear drops the arriving cause. Masked and globally disabled pulses, an all-sources burst, and a combined reset-plus-software command separate gating, bit placement and command priority. A behavioural reference model is compared against the line and the read data on every cycle.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    localparam int NSRC     = 9;
    localparam int HW_SRC   = 8;
    localparam int SOFT_BIT = 8;

    localparam logic [NSRC-1:0] SRC_VALID = 9'h1FF;
    localparam logic [NSRC-1:0] IMM_MASK  = 9'h1CC;
    localparam logic [NSRC-1:0] COAL_MASK = SRC_VALID & ~IMM_MASK;

    localparam int ADR_CFG  = 0;
    localparam int ADR_CMD  = 1;
    localparam int ADR_STAT = 2;
    localparam int ADR_MASK = 3;
    localparam int ADR_DLY  = 4;

    localparam int CFG_IEN_BIT  = 2;
    localparam int CMD_RST_BIT  = 0;
    localparam int CMD_SOFT_BIT = 1;

    typedef struct packed {
        logic soft_rst;
        logic soft_irq;
        logic stat_rd;
    } reg_op_t;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_COUNT = 2'd1,
        C_FIRED = 2'd2
    } coal_state_e;

    function automatic logic any_in(input logic [NSRC-1:0] v, input logic [NSRC-1:0] grp);
        return |(v & grp);
    endfunction

endpackage

// File: rtl/nic_irq_regfile.sv
module nic_irq_regfile
    import nic_irq_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 3,
    parameter int DLY_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [NSRC-1:0]   status,
    output logic              int_en,
    output logic [NSRC-1:0]   mask,
    output logic [DLY_W-1:0]  delay,
    output reg_op_t           op,
    output logic [REG_W-1:0]  rdata
);

    logic wr_cfg, wr_cmd, wr_mask, wr_dly, rd_stat, clr;
    logic [REG_W-1:0] rd_mux;
    logic unused_wbits;

    assign wr_cfg  = reg_wr && (reg_addr == ADDR_W'(ADR_CFG));
    assign wr_cmd  = reg_wr && (reg_addr == ADDR_W'(ADR_CMD));
    assign wr_mask = reg_wr && (reg_addr == ADDR_W'(ADR_MASK));
    assign wr_dly  = reg_wr && (reg_addr == ADDR_W'(ADR_DLY));
    assign rd_stat = reg_rd && (reg_addr == ADDR_W'(ADR_STAT));

    // reset request outranks the software interrupt request
    assign op.soft_rst = wr_cmd && reg_wdata[CMD_RST_BIT];
    assign op.soft_irq = wr_cmd && reg_wdata[CMD_SOFT_BIT] && !reg_wdata[CMD_RST_BIT];
    assign op.stat_rd  = rd_stat;

    assign clr = rst || op.soft_rst;
    assign unused_wbits = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (clr) begin
            int_en <= 1'b0;
            mask   <= SRC_VALID;
            delay  <= '0;
        end else begin
            if (wr_cfg)  int_en <= reg_wdata[CFG_IEN_BIT];
            if (wr_mask) mask   <= reg_wdata[NSRC-1:0];
            if (wr_dly)  delay  <= reg_wdata[DLY_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(ADR_CFG))       rd_mux[CFG_IEN_BIT] = int_en;
        else if (reg_addr == ADDR_W'(ADR_STAT)) rd_mux[NSRC-1:0]    = status;
        else if (reg_addr == ADDR_W'(ADR_MASK)) rd_mux[NSRC-1:0]    = mask;
        else if (reg_addr == ADDR_W'(ADR_DLY))  rd_mux[DLY_W-1:0]   = delay;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (reg_rd) rdata <= rd_mux;
    end

endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_irq_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic [HW_SRC-1:0] hw_evt,
    input  logic              soft_set,
    input  logic              rd_clr,
    output logic [NSRC-1:0]   status
);

    logic [NSRC-1:0] set_vec;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (i == SOFT_BIT) begin : g_soft
            assign set_vec[i] = soft_set;
        end else begin : g_hw
            assign set_vec[i] = hw_evt[i];
        end

        // a new cause in the clearing cycle survives the clear
        always_ff @(posedge clk) begin
            if (clr) status[i] <= 1'b0;
            else     status[i] <= (status[i] && !rd_clr) || set_vec[i];
        end
    end

endmodule

// File: rtl/nic_irq_coalesce.sv
module nic_irq_coalesce
    import nic_irq_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             pend,
    input  logic [DLY_W-1:0] delay,
    output logic             fire
);

    coal_state_e      state;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || !pend) begin
            state <= C_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                C_IDLE: begin
                    if (delay == '0) begin
                        state <= C_FIRED;
                    end else begin
                        state <= C_COUNT;
                        cnt   <= delay;
                    end
                end
                C_COUNT: begin
                    if (cnt == DLY_W'(1)) state <= C_FIRED;
                    else                  cnt   <= cnt - 1'b1;
                end
                default: state <= C_FIRED;
            endcase
        end
    end

    assign fire = (state == C_FIRED);

endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
    import nic_irq_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 3,
    parameter int DLY_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        evt_i,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);

    logic [NSRC-1:0]  status_q, mask_q, enabled;
    logic [DLY_W-1:0] dly_q;
    logic             int_en, coal_fire, coal_any, imm_any, blk_clr;
    reg_op_t          op;

    nic_irq_regfile #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status_q),
        .int_en    (int_en),
        .mask      (mask_q),
        .delay     (dly_q),
        .op        (op),
        .rdata     (reg_rdata)
    );

    assign blk_clr = rst || op.soft_rst;

    nic_irq_status u_stat (
        .clk      (clk),
        .clr      (blk_clr),
        .hw_evt   (evt_i),
        .soft_set (op.soft_irq),
        .rd_clr   (op.stat_rd),
        .status   (status_q)
    );

    assign enabled  = status_q & mask_q;
    assign imm_any  = any_in(enabled, IMM_MASK);
    assign coal_any = any_in(enabled, COAL_MASK);

    nic_irq_coalesce #(.DLY_W(DLY_W)) u_coal (
        .clk   (clk),
        .clr   (blk_clr),
        .pend  (coal_any),
        .delay (dly_q),
        .fire  (coal_fire)
    );

    assign irq_o = int_en && (imm_any || (coal_fire && coal_any));

endmodule

// File: rtl/nic_irq_chk.sv
module nic_irq_chk
    import nic_irq_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        evt_i,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq_o,
    input logic [NSRC-1:0]   status,
    input logic [NSRC-1:0]   mask,
    input logic              int_en,
    input logic              fire,
    input logic              coal_any
);

    // R6
    stat_read_data_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_W'(ADR_STAT)) |=> (reg_rdata == REG_W'($past(status))));

    // R6
    stat_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == ADDR_W'(ADR_STAT)) |=> (status == {1'b0, $past(evt_i)}));

    // R3
    soft_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(ADR_CMD) && reg_wdata[CMD_SOFT_BIT] && !reg_wdata[CMD_RST_BIT])
        |=> status[SOFT_BIT]);

    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(ADR_CMD) && reg_wdata[CMD_RST_BIT])
        |=> (status == '0 && mask == SRC_VALID && !int_en));

    // R8
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq_o);

    // R5
    fire_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fire) |-> $past(coal_any));

endmodule

bind nic_irq_ctrl nic_irq_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .status    (status_q),
    .mask      (mask_q),
    .int_en    (int_en),
    .fire      (coal_fire),
    .coal_any  (coal_any)
);

// File: tb/tb_nic_irq_ctrl.sv
`timescale 1ns/1ps
module tb_nic_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt_i = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    nic_irq_ctrl dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // behavioural reference model
    int m_status, m_mask, m_en, m_delay, m_tmr, m_rdata;
    bit m_active, m_fired, m_rvalid;

    always @(posedge clk) begin
        int sets, cp;
        if (rst) begin
            m_status = 0; m_mask = 'h1FF; m_en = 0; m_delay = 0;
            m_tmr = 0; m_active = 0; m_fired = 0; m_rdata = 0; m_rvalid = 0;
        end else begin
            m_rvalid = reg_rd;
            if (reg_rd) begin
                case (reg_addr)
                    3'd0: m_rdata = m_en ? 4 : 0;
                    3'd2: m_rdata = m_status;
                    3'd3: m_rdata = m_mask;
                    3'd4: m_rdata = m_delay;
                    default: m_rdata = 0;
                endcase
            end
            cp = m_status & m_mask & 'h033;
            if (cp == 0) begin
                m_active = 0; m_fired = 0; m_tmr = 0;
            end else if (!m_active && !m_fired) begin
                if (m_delay == 0) m_fired = 1;
                else begin m_active = 1; m_tmr = m_delay; end
            end else if (m_active) begin
                m_tmr--;
                if (m_tmr == 0) begin m_active = 0; m_fired = 1; end
            end
            sets = evt_i;
            if (reg_wr && reg_addr == 3'd1 && reg_wdata[1] && !reg_wdata[0]) sets |= 'h100;
            if (reg_rd && reg_addr == 3'd2) m_status = sets;
            else m_status |= sets;
            if (reg_wr && reg_addr == 3'd0) m_en = reg_wdata[2];
            if (reg_wr && reg_addr == 3'd3) m_mask = reg_wdata & 'h1FF;
            if (reg_wr && reg_addr == 3'd4) m_delay = reg_wdata & 'hFFFF;
            if (reg_wr && reg_addr == 3'd1 && reg_wdata[0]) begin
                m_status = 0; m_mask = 'h1FF; m_en = 0; m_delay = 0;
                m_active = 0; m_fired = 0; m_tmr = 0;
            end
        end
    end

    function automatic bit model_irq();
        int en_v;
        en_v = m_status & m_mask;
        return (m_en != 0) && (((en_v & 'h1CC) != 0) || (m_fired && ((en_v & 'h033) != 0)));
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(cur_req, "irq_o vs model", int'(irq_o), int'(model_irq()));
            if (m_rvalid) chk(cur_req, "reg_rdata vs model", int'(reg_rdata), m_rdata);
        end
    end

    task automatic wr(input int a, input int d);
        reg_wr = 1; reg_addr = 3'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output int d);
        reg_rd = 1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 0;
        d = int'(reg_rdata);
    endtask

    task automatic pulse(input int e);
        evt_i = 8'(e);
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        summary();
    end

    initial begin
        int d;
        idle(3);
        rst = 0;
        @(negedge clk);

        // R1 reset values
        cur_req = "R1";
        chk("R1", "irq after reset", int'(irq_o), 0);
        rd(2, d); chk("R1", "status", d, 0);
        rd(3, d); chk("R1", "mask", d, 'h1FF);
        rd(0, d); chk("R1", "config", d, 0);
        rd(4, d); chk("R1", "delay", d, 0);

        wr(0, 4); wr(4, 5);

        // R4 immediate source, R10 clears
        cur_req = "R4";
        pulse('h04);
        chk("R4", "immediate irq", int'(irq_o), 1);
        cur_req = "R10";
        rd(2, d); chk("R6", "status read bit2", d, 'h004);
        chk("R10", "irq after clearing read", int'(irq_o), 0);

        // R5 coalesced with mid-count extra event, delay 5
        cur_req = "R5";
        pulse('h01);
        for (int k = 1; k <= 5; k++) begin
            if (k == 2) evt_i = 8'h02;
            @(negedge clk);
            evt_i = '0;
            chk("R5", "irq held during countdown", int'(irq_o), 0);
        end
        @(negedge clk);
        chk("R5", "irq at D+1", int'(irq_o), 1);

        // R6 read with simultaneous event
        cur_req = "R6";
        evt_i = 8'h20;
        rd(2, d);
        evt_i = '0;
        chk("R6", "read returns pre-clear bits", d, 'h003);
        rd(2, d); chk("R6", "event in read cycle kept", d, 'h020);
        idle(2);
        chk("R10", "irq low after clear", int'(irq_o), 0);

        // R3 software interrupt
        cur_req = "R3";
        wr(1, 2);
        chk("R3", "soft irq immediate", int'(irq_o), 1);
        rd(2, d); chk("R3", "status bit8", d, 'h100);

        // R7 masked source
        cur_req = "R7";
        wr(3, 'h1F7);
        pulse('h08);
        idle(3);
        chk("R7", "masked source no irq", int'(irq_o), 0);
        rd(2, d); chk("R7", "masked source recorded", d, 'h008);
        wr(3, 'h1FF);

        // R8 global enable
        cur_req = "R8";
        wr(0, 0);
        pulse('h40);
        idle(2);
        chk("R8", "disabled irq low", int'(irq_o), 0);
        wr(0, 4);
        chk("R8", "enable releases irq", int'(irq_o), 1);
        rd(2, d); chk("R8", "status bit6", d, 'h040);

        // R11 zero delay
        cur_req = "R11";
        wr(4, 0);
        pulse('h10);
        chk("R11", "irq not yet", int'(irq_o), 0);
        @(negedge clk);
        chk("R11", "irq one cycle later", int'(irq_o), 1);
        rd(2, d); chk("R11", "status bit4", d, 'h010);

        // R2 all hardware sources
        cur_req = "R2";
        pulse('hFF);
        chk("R2", "irq with burst", int'(irq_o), 1);
        rd(2, d); chk("R2", "all hw bits, upper zero", d, 'h0FF);

        // R9 soft reset beats soft irq
        cur_req = "R9";
        wr(4, 7); wr(3, 'h0F0);
        pulse('h44);
        wr(1, 3);
        chk("R9", "irq after soft reset", int'(irq_o), 0);
        rd(2, d); chk("R9", "status", d, 0);
        rd(3, d); chk("R9", "mask", d, 'h1FF);
        rd(0, d); chk("R9", "config", d, 0);
        rd(4, d); chk("R9", "delay", d, 0);

        idle(2);
        summary();
    end

endmodule